// File: doc/BRIEF.md
# Mesh Vertex Sequencer

This block is the control engine of a mesh-processing coprocessor. A host writes a control word with bit 0 set, and the sequencer then walks a rectangular grid of vertices. The row index is the outer loop and the column index is the inner loop. For each vertex it presents the grid coordinates, which the attached datapath loads into its two coordinate registers. It then restarts the microprogram at address zero and waits for the program's output-vector instruction. The datapath itself sits outside this block.

The output instruction hands over two 32-bit words. The sequencer writes them in big-endian byte order to a fixed slot of a vertex array in memory, one word at a time, through a request/acknowledge write port. The slot for vertex (x, y) is at base + 1024*y + 8*x; this is a row pitch of 128 entries of 8 bytes. If a program runs through its whole instruction budget without an output instruction, that vertex is dropped and the walk goes on. When the last vertex is done, the block posts the vertex count, clears busy and pulses the interrupt.

Top module: `vertex_walker`

## Requirements
- R1: A control write with bit 0 set, made while idle, sets `busy` in the next cycle and begins the walk at (0,0). A control write with bit 0 clear has no effect.
- R2: Vertices are visited with y from 0 to `cfg_vlast` inclusive as the outer loop and x from 0 to `cfg_hlast` inclusive as the inner loop. The values used are those captured at start.
- R3: Each vertex begins with a one-cycle `vtx_launch` pulse that carries that vertex's x on `vtx_x` and y on `vtx_y`.
- R4: For each output instruction, two writes are issued. The first carries `prog_word_a` to base + 1024*y + 8*x. The second carries `prog_word_b` to that address + 4.
- R5: Write data is byte-reversed: bits [7:0] of the word travel on `mem_data[31:24]`, and so on, so that memory holds the word big-endian.
- R6: `prog_step` counts instructions that are not output instructions. If the 2048th such pulse of a vertex arrives with no output instruction before it, the vertex is dropped with no write. With 2047 pulses, a following output instruction is still written.
- R7: After each completed write pair, `last_dma` holds the address of the second word. It keeps that value until the next pair completes.
- R8: When the grid is complete, `vertex_count` becomes (hlast+1)*(vlast+1) and `irq` is high for exactly one cycle.
- R9: `busy` falls in the same cycle that `irq` is high. A start write while busy is ignored and does not restart the walk after it ends.
- R10: `mem_req` stays high with stable address and data until `mem_ack`. No new vertex is launched while a write is pending.
- R11: After reset, `busy`, `irq`, `mem_req` and `vtx_launch` are low, and `vertex_count` and `last_dma` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Host control-register write strobe |
| ctl_wdata | input | 32 | Control write data; bit 0 requests a start |
| cfg_base | input | ADDR_W | Byte address of the vertex array |
| cfg_hlast | input | COORD_W | Last column index |
| cfg_vlast | input | COORD_W | Last row index |
| busy | output | 1 | Control bit 0 readback: walk in progress |
| irq | output | 1 | One-cycle completion pulse |
| vertex_count | output | VCNT_W | Vertices in the last completed grid |
| last_dma | output | ADDR_W | Address of the last second word written |
| vtx_launch | output | 1 | Load coordinates and restart the program at 0 |
| vtx_x | output | COORD_W | Column index for coordinate register 0 |
| vtx_y | output | COORD_W | Row index for coordinate register 1 |
| prog_step | input | 1 | One non-output instruction executed |
| prog_vout | input | 1 | Output instruction executed |
| prog_word_a | input | 32 | First output word |
| prog_word_b | input | 32 | Second output word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 32 | Write data, byte-reversed |
| mem_ack | input | 1 | Write accepted this cycle |

## Verification
Two events can fall in the same cycle: the end of the walk, shown by the `irq` pulse, and the drop of `busy`. A stray start write can also arrive while the walk is still running. The bench issues a second start in the middle of each grid. In the cycle where `irq` is seen it requires `busy` already low, and one cycle later it requires `irq` low and `busy` still low, so the stray start caused no restart. The same cycle-exact sampling is used for the drop after an exhausted budget: a 2048-step vertex must produce no write, while a 2047-step one must.

// File: rtl/vertex_walker_pkg.sv
package vertex_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_WRITE,
        ST_STEP
    } walk_state_t;

    typedef struct packed {
        logic [31:0] first;
        logic [31:0] second;
    } word_pair_t;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/grid_walker.sv
module grid_walker #(
    parameter int COORD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               advance,
    input  logic [COORD_W-1:0] hlast,
    input  logic [COORD_W-1:0] vlast,
    output logic [COORD_W-1:0] gx,
    output logic [COORD_W-1:0] gy,
    output logic               at_last
);
    assign at_last = (gx == hlast) && (gy == vlast);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gx <= '0;
            gy <= '0;
        end else if (advance) begin
            if (gx == hlast) begin
                gx <= '0;
                gy <= gy + COORD_W'(1);
            end else begin
                gx <= gx + COORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/insn_budget.sv
module insn_budget #(
    parameter int BUDGET = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic spent
);
    localparam int CW = (BUDGET > 1) ? $clog2(BUDGET) : 1;

    logic [CW-1:0] used;

    assign spent = step && (used == CW'(BUDGET - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            used <= '0;
        else if (step && !spent)
            used <= used + CW'(1);
    end
endmodule

// File: rtl/pair_writer.sv
module pair_writer
    import vertex_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] slot_addr,
    input  word_pair_t        words,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       data,
    output logic              done
);
    logic              pend;
    logic              phase;
    logic [ADDR_W-1:0] slot_q;
    word_pair_t        words_q;

    assign req  = pend;
    assign addr = phase ? slot_q + ADDR_W'(4) : slot_q;
    assign data = swap_bytes(phase ? words_q.second : words_q.first);
    assign done = pend && ack && phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            phase   <= 1'b0;
            slot_q  <= '0;
            words_q <= '0;
        end else if (go) begin
            pend    <= 1'b1;
            phase   <= 1'b0;
            slot_q  <= slot_addr;
            words_q <= words;
        end else if (pend && ack) begin
            if (phase) begin
                pend  <= 1'b0;
                phase <= 1'b0;
            end else begin
                phase <= 1'b1;
            end
        end
    end

    AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (req && ack && !phase) |=> (req && addr == $past(addr) + ADDR_W'(4))); // R4
endmodule

// File: rtl/vertex_walker.sv
module vertex_walker
    import vertex_walker_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int COORD_W     = 8,
    parameter int INSN_BUDGET = 2048,
    parameter int ROW_PITCH   = 128,
    parameter int ENTRY_BYTES = 8,
    localparam int VCNT_W     = 2 * COORD_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [31:0]        ctl_wdata,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [COORD_W-1:0] cfg_hlast,
    input  logic [COORD_W-1:0] cfg_vlast,
    output logic               busy,
    output logic               irq,
    output logic [VCNT_W-1:0]  vertex_count,
    output logic [ADDR_W-1:0]  last_dma,
    output logic               vtx_launch,
    output logic [COORD_W-1:0] vtx_x,
    output logic [COORD_W-1:0] vtx_y,
    input  logic               prog_step,
    input  logic               prog_vout,
    input  logic [31:0]        prog_word_a,
    input  logic [31:0]        prog_word_b,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_data,
    input  logic               mem_ack
);
    localparam int ROW_SH = $clog2(ROW_PITCH * ENTRY_BYTES);
    localparam int COL_SH = $clog2(ENTRY_BYTES);

    walk_state_t        state;
    logic [ADDR_W-1:0]  base_q;
    logic [COORD_W-1:0] hlast_q, vlast_q;
    logic [COORD_W-1:0] gx, gy;
    logic               at_last;
    logic               start_fire, advance, budget_hit, wr_go, wr_done;
    logic [ADDR_W-1:0]  slot_addr;
    word_pair_t         words;

    assign start_fire = (state == ST_IDLE) && ctl_wr && ctl_wdata[0];
    assign advance    = (state == ST_STEP) && !at_last;
    assign wr_go      = (state == ST_RUN) && prog_vout;
    assign vtx_launch = (state == ST_LAUNCH);
    assign vtx_x      = gx;
    assign vtx_y      = gy;
    assign slot_addr  = base_q + (ADDR_W'(gy) << ROW_SH) + (ADDR_W'(gx) << COL_SH);
    assign words      = '{first: prog_word_a, second: prog_word_b};

    grid_walker #(.COORD_W(COORD_W)) u_grid (
        .clk(clk), .rst(rst), .clear(start_fire), .advance(advance),
        .hlast(hlast_q), .vlast(vlast_q), .gx(gx), .gy(gy), .at_last(at_last)
    );

    insn_budget #(.BUDGET(INSN_BUDGET)) u_budget (
        .clk(clk), .rst(rst), .clear(vtx_launch),
        .step(prog_step && state == ST_RUN), .spent(budget_hit)
    );

    pair_writer #(.ADDR_W(ADDR_W)) u_writer (
        .clk(clk), .rst(rst), .go(wr_go), .slot_addr(slot_addr), .words(words),
        .ack(mem_ack), .req(mem_req), .addr(mem_addr), .data(mem_data),
        .done(wr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            busy         <= 1'b0;
            irq          <= 1'b0;
            base_q       <= '0;
            hlast_q      <= '0;
            vlast_q      <= '0;
            vertex_count <= '0;
            last_dma     <= '0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_fire) begin
                    base_q  <= cfg_base;
                    hlast_q <= cfg_hlast;
                    vlast_q <= cfg_vlast;
                    busy    <= 1'b1;
                    state   <= ST_LAUNCH;
                end
                ST_LAUNCH: state <= ST_RUN;
                ST_RUN: begin
                    if (prog_vout)
                        state <= ST_WRITE;
                    else if (budget_hit)
                        state <= ST_STEP;
                end
                ST_WRITE: if (wr_done) begin
                    last_dma <= mem_addr;
                    state    <= ST_STEP;
                end
                ST_STEP: begin
                    if (at_last) begin
                        vertex_count <= (VCNT_W'(hlast_q) + VCNT_W'(1))
                                      * (VCNT_W'(vlast_q) + VCNT_W'(1));
                        busy  <= 1'b0;
                        irq   <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_LAUNCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8
    AST_BUSY_DROP_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R10
    AST_NO_LAUNCH_PENDING: assert property (@(posedge clk) disable iff (rst)
        vtx_launch |-> !mem_req); // R10
    AST_BUDGET_DROP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && budget_hit && !prog_vout) |=> !mem_req); // R6
endmodule

// File: tb/tb_vertex_walker.sv
module tb_vertex_walker;
    localparam int ADDR_W = 32;
    localparam int COORD_W = 8;
    localparam int VCNT_W = 2 * COORD_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [COORD_W-1:0] cfg_hlast = '0, cfg_vlast = '0;
    logic busy, irq, vtx_launch, mem_req;
    logic [VCNT_W-1:0] vertex_count;
    logic [ADDR_W-1:0] last_dma, mem_addr;
    logic [COORD_W-1:0] vtx_x, vtx_y;
    logic prog_step = 1'b0, prog_vout = 1'b0, mem_ack = 1'b0;
    logic [31:0] prog_word_a = '0, prog_word_b = '0, mem_data;

    always #4 clk = ~clk;

    vertex_walker dut (.*);

    int n_checks = 0, n_fail = 0;

    // stub and expectation state
    int steps_norm, alt_steps, alt_x, ack_lat;
    bit alt_en;
    int ex, ey, cur_x, cur_y, loads, writes, ack_cnt, stub_cnt;
    bit armed, half;
    logic [31:0] base_run, exp_last = '0;

    // stimulus table: hlast, vlast, steps, ack latency, base
    localparam logic [63:0] VEC [4] = '{
        {8'd2, 8'd1, 12'd3, 4'd0, 32'h1000_0000},
        {8'd0, 8'd0, 12'd0, 4'd2, 32'h2000_0040},
        {8'd4, 8'd2, 12'd1, 4'd1, 32'h0000_8000},
        {8'd7, 8'd0, 12'd5, 4'd3, 32'hFFFF_F000}
    };

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic stub_loop();
        forever begin
            @(negedge clk);
            prog_step = 1'b0;
            prog_vout = 1'b0;
            if (vtx_launch) begin
                check(vtx_x == COORD_W'(ex) && vtx_y == COORD_W'(ey), "R2/R3 launch coords",
                      {vtx_x, vtx_y}, {COORD_W'(ex), COORD_W'(ey)});
                cur_x = ex; cur_y = ey; loads++;
                if (ex == int'(cfg_hlast)) begin ex = 0; ey++; end else ex++;
                stub_cnt = (alt_en && cur_x == alt_x) ? alt_steps : steps_norm;
                armed = 1'b1;
                half = 1'b0;
            end else if (armed) begin
                if (stub_cnt > 0) begin
                    prog_step = 1'b1;
                    stub_cnt--;
                end else begin
                    prog_vout = 1'b1;
                    prog_word_a = {8'hA5, 8'(cur_y), 8'(cur_x), 8'h3C};
                    prog_word_b = {8'h5A, 8'(cur_x), 8'(cur_y), 8'hC3};
                    armed = 1'b0;
                end
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
                ack_cnt = 0;
            end else if (mem_req) begin
                if (ack_cnt >= ack_lat) begin
                    logic [31:0] ea, ed;
                    ea = base_run + 32'(cur_y) * 1024 + 32'(cur_x) * 8 + (half ? 32'd4 : 32'd0);
                    ed = half ? bswap({8'h5A, 8'(cur_x), 8'(cur_y), 8'hC3})
                              : bswap({8'hA5, 8'(cur_y), 8'(cur_x), 8'h3C});
                    check(mem_addr == ea, "R4 write address", mem_addr, ea);
                    check(mem_data == ed, "R5 byte order", mem_data, ed);
                    if (half) begin exp_last = ea; writes++; end
                    half = !half;
                    mem_ack = 1'b1;
                end else begin
                    ack_cnt++;
                end
            end
        end
    endtask

    task automatic run_grid(input int h, input int v, input int st, input int lat,
                            input logic [31:0] base, input bit aen, input int ax,
                            input int ast, input int exp_writes);
        int guard;
        cfg_hlast = COORD_W'(h); cfg_vlast = COORD_W'(v); cfg_base = base;
        steps_norm = st; ack_lat = lat; alt_en = aen; alt_x = ax; alt_steps = ast;
        base_run = base; ex = 0; ey = 0; loads = 0; writes = 0; ack_cnt = 0;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 32'h0000_0001;
        @(negedge clk);
        ctl_wr = 1'b0;
        check(busy == 1'b1, "R1 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        ctl_wr = 1'b1;                       // stray start while busy (R9)
        @(negedge clk);
        ctl_wr = 1'b0;
        guard = 0;
        while (!irq && guard < 20000) begin @(negedge clk); guard++; end
        check(guard < 20000, "R8 irq arrives", guard, 0);
        check(busy == 1'b0, "R9 busy low with irq", busy, 0);
        check(vertex_count == VCNT_W'((h + 1) * (v + 1)), "R8 vertex count",
              vertex_count, (h + 1) * (v + 1));
        check(last_dma == exp_last, "R7 last dma", last_dma, exp_last);
        check(loads == (h + 1) * (v + 1), "R2 launches", loads, (h + 1) * (v + 1));
        check(writes == exp_writes, "R6 write pairs", writes, exp_writes);
        @(negedge clk);
        check(irq == 1'b0, "R8 irq one cycle", irq, 0);
        check(busy == 1'b0 && !vtx_launch, "R9 stray start ignored", busy, 0);
    endtask

    initial begin
        fork stub_loop(); join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!busy && !irq && !mem_req && !vtx_launch, "R11 reset outputs",
              {busy, irq, mem_req, vtx_launch}, 0);
        check(vertex_count == 0 && last_dma == 0, "R11 reset status",
              {vertex_count, last_dma}, 0);
        // R1 control write with bit 0 clear
        ctl_wr = 1'b1; ctl_wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
        check(!busy && !vtx_launch, "R1 bit0 clear ignored", busy, 0);
        // table walk
        for (int i = 0; i < 4; i++) begin
            run_grid(int'(VEC[i][63:56]), int'(VEC[i][55:48]), int'(VEC[i][47:36]),
                     int'(VEC[i][35:32]), VEC[i][31:0], 1'b0, 0, 0,
                     (int'(VEC[i][63:56]) + 1) * (int'(VEC[i][55:48]) + 1));
        end
        // R6 budget boundary: 2047 steps written, 2048 steps dropped
        run_grid(2, 0, 2047, 1, 32'h4000_0000, 1'b1, 1, 2048, 2);
        // R6/R7 last vertex dropped: last_dma keeps previous value
        run_grid(0, 0, 0, 0, 32'h5000_0000, 1'b1, 0, 2048, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule